// File: doc/BRIEF.md
# Accumulator Fetch-Execute Core

This block is a small processor core built around a single 16-bit accumulator. It runs a two-phase instruction cycle. In the fetch phase it reads the word addressed by the program counter into the instruction register and advances the counter. In the execute phase it decodes the opcode in the top field and carries out a load, a store or an add against the word at the 12-bit direct address in the low field. All traffic to the single synchronous word-addressed memory passes through an address register and a data buffer register. The memory returns read data one clock after it sees an address.

A system that uses the core presents a start address and holds reset. It then releases reset and lets the core run until a word with an unknown opcode raises the halt flag. Results are read back from memory, or from the accumulator and program counter outputs. Each phase uses a fixed number of clocks, so every instruction has a fixed duration. A fetch takes 4 cycles. A load or add execute takes 4 cycles, and a store execute takes 2.

Top module: `acc_core`

## Requirements
- R1: While reset is high and in the first cycle after it falls, pc_out equals start_addr, acc_out is 0, halted is 0 and mem_we is 0. The first fetch reads from start_addr.
- R2: An instruction word carries its opcode in bits 15:12 and its operand address in bits 11:0. The operand address reaches 4096 words directly.
- R3: Each fetch drives pc_out onto mem_addr in the second cycle of the instruction. pc_out increases by exactly one at the end of the fourth cycle and wraps from 0xFFF to 0x000. A program started at 0x300 fetches from 0x300, 0x301 and 0x302 in turn.
- R4: Opcode 0001 copies the memory word at the operand address into the accumulator. The new acc_out is visible in the ninth cycle after the instruction's first cycle.
- R5: Opcode 0010 drives the accumulator onto mem_wdata and the operand address onto mem_addr, and holds mem_we high for exactly one cycle, the sixth of the instruction. The accumulator does not change. The next fetch starts in the seventh cycle.
- R6: Opcode 0101 adds the memory word at the operand address to the accumulator, modulo 2^16, with no flags. Timing is the same as R4.
- R7: Any other opcode raises halted in the sixth cycle of that instruction. halted stays high until reset. While halted, there is no further fetch or write, and pc_out (already advanced past the bad word) and mem_addr stay frozen.
- R8: The program load 0x940, add 0x941, store 0x941 leaves the sum of the two original words in location 0x941.
- R9: mem_addr comes from the address register and mem_wdata from the data buffer register. Read data is sampled one cycle after its address was presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| start_addr | input | 12 | Program counter value loaded during reset |
| mem_addr | output | 12 | Memory word address (address register) |
| mem_we | output | 1 | Memory write strobe, one cycle per store |
| mem_wdata | output | 16 | Memory write data (data buffer register) |
| mem_rdata | input | 16 | Memory read data, valid one cycle after its address |
| acc_out | output | 16 | Accumulator contents |
| pc_out | output | 12 | Program counter contents |
| halted | output | 1 | Sticky flag raised by an unknown opcode |

## Verification
A behavioural model in the bench counts each instruction's cycles from its first cycle. Under that count, the fetch address is due in cycle 2, the counter step after cycle 4 and a halt after cycle 5. A store's write strobe is due in cycle 6, and a load or add result after cycle 8. The model advances on the same rising edge as the design, and every output is compared on the following falling edge. A value that arrives one cycle early or late therefore fails in the exact cycle it differs. Memory contents, and the frozen state after a halt, are checked against constants worked out by hand for each program.

// File: rtl/acc_pkg.sv
`timescale 1ns/1ps
package acc_pkg;

  // Phase sequencer states: four fetch steps, four execute steps, halt.
  typedef enum logic [3:0] {
    PH_F_ADDR  = 4'd0,
    PH_F_WAIT  = 4'd1,
    PH_F_CAPT  = 4'd2,
    PH_F_LOAD  = 4'd3,
    PH_X_DEC   = 4'd4,
    PH_X_MEM   = 4'd5,
    PH_X_CAPT  = 4'd6,
    PH_X_DONE  = 4'd7,
    PH_STOPPED = 4'd8
  } phase_t;

  // Decoded operation class.
  typedef enum logic [1:0] {
    OPK_LOAD  = 2'd0,
    OPK_STORE = 2'd1,
    OPK_ADD   = 2'd2,
    OPK_BAD   = 2'd3
  } op_kind_t;

endpackage

// File: rtl/acc_decode.sv
`timescale 1ns/1ps
module acc_decode
  import acc_pkg::*;
#(
  parameter int OP_W = 4,
  parameter logic [OP_W-1:0] CODE_LOAD  = OP_W'(1),
  parameter logic [OP_W-1:0] CODE_STORE = OP_W'(2),
  parameter logic [OP_W-1:0] CODE_ADD   = OP_W'(5)
) (
  input  logic [OP_W-1:0] opcode,
  output op_kind_t        kind
);

  always_comb begin
    if (opcode == CODE_LOAD)       kind = OPK_LOAD;
    else if (opcode == CODE_STORE) kind = OPK_STORE;
    else if (opcode == CODE_ADD)   kind = OPK_ADD;
    else                           kind = OPK_BAD;
  end

endmodule

// File: rtl/acc_seq.sv
`timescale 1ns/1ps
module acc_seq
  import acc_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  op_kind_t kind,
  output phase_t   phase,
  output logic     halted
);

  phase_t phase_q;
  logic   halt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      phase_q <= PH_F_ADDR;
      halt_q  <= 1'b0;
    end else begin
      case (phase_q)
        PH_F_ADDR: phase_q <= PH_F_WAIT;
        PH_F_WAIT: phase_q <= PH_F_CAPT;
        PH_F_CAPT: phase_q <= PH_F_LOAD;
        PH_F_LOAD: phase_q <= PH_X_DEC;
        PH_X_DEC: begin
          if (kind == OPK_BAD) begin
            phase_q <= PH_STOPPED;
            halt_q  <= 1'b1;
          end else begin
            phase_q <= PH_X_MEM;
          end
        end
        PH_X_MEM:  phase_q <= (kind == OPK_STORE) ? PH_F_ADDR : PH_X_CAPT;
        PH_X_CAPT: phase_q <= PH_X_DONE;
        PH_X_DONE: phase_q <= PH_F_ADDR;
        default:   phase_q <= PH_STOPPED;
      endcase
    end
  end

  assign phase  = phase_q;
  assign halted = halt_q;

endmodule

// File: rtl/acc_datapath.sv
`timescale 1ns/1ps
module acc_datapath
  import acc_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] start_addr,
  input  phase_t            phase,
  input  op_kind_t          kind,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic [ADDR_W-1:0] pc,
  output logic [ADDR_W-1:0] mar,
  output logic [DATA_W-1:0] mbr,
  output logic [DATA_W-1:0] ir,
  output logic [DATA_W-1:0] acc,
  output logic              we
);

  always_ff @(posedge clk) begin
    if (rst) begin
      pc  <= start_addr;
      mar <= '0;
      mbr <= '0;
      ir  <= '0;
      acc <= '0;
      we  <= 1'b0;
    end else begin
      we <= 1'b0;
      case (phase)
        PH_F_ADDR: mar <= pc;
        PH_F_CAPT: mbr <= mem_rdata;
        PH_F_LOAD: begin
          ir <= mbr;
          pc <= pc + 1'b1;
        end
        PH_X_DEC: begin
          if (kind != OPK_BAD) mar <= ir[ADDR_W-1:0];
          if (kind == OPK_STORE) begin
            mbr <= acc;
            we  <= 1'b1;
          end
        end
        PH_X_CAPT: mbr <= mem_rdata;
        PH_X_DONE: begin
          if (kind == OPK_LOAD)     acc <= mbr;
          else if (kind == OPK_ADD) acc <= acc + mbr;
        end
        default: ;
      endcase
    end
  end

endmodule

// File: rtl/acc_core.sv
`timescale 1ns/1ps
module acc_core
  import acc_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int OP_W   = 4
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic [DATA_W-OP_W-1:0]   start_addr,
  output logic [DATA_W-OP_W-1:0]   mem_addr,
  output logic                     mem_we,
  output logic [DATA_W-1:0]        mem_wdata,
  input  logic [DATA_W-1:0]        mem_rdata,
  output logic [DATA_W-1:0]        acc_out,
  output logic [DATA_W-OP_W-1:0]   pc_out,
  output logic                     halted
);

  localparam int ADDR_W = DATA_W - OP_W;

  phase_t            phase;
  op_kind_t          kind;
  logic [ADDR_W-1:0] pc_r;
  logic [ADDR_W-1:0] mar_r;
  logic [DATA_W-1:0] mbr_r;
  logic [DATA_W-1:0] ir_r;
  logic [DATA_W-1:0] acc_r;
  logic              we_r;

  acc_decode #(.OP_W(OP_W)) u_dec (
    .opcode (ir_r[DATA_W-1 -: OP_W]),
    .kind   (kind)
  );

  acc_seq u_seq (
    .clk    (clk),
    .rst    (rst),
    .kind   (kind),
    .phase  (phase),
    .halted (halted)
  );

  acc_datapath #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_dp (
    .clk        (clk),
    .rst        (rst),
    .start_addr (start_addr),
    .phase      (phase),
    .kind       (kind),
    .mem_rdata  (mem_rdata),
    .pc         (pc_r),
    .mar        (mar_r),
    .mbr        (mbr_r),
    .ir         (ir_r),
    .acc        (acc_r),
    .we         (we_r)
  );

  assign mem_addr  = mar_r;
  assign mem_we    = we_r;
  assign mem_wdata = mbr_r;
  assign acc_out   = acc_r;
  assign pc_out    = pc_r;

endmodule

// File: rtl/acc_core_chk.sv
`timescale 1ns/1ps
module acc_core_chk #(
  parameter int DATA_W = 16,
  parameter int OP_W   = 4
) (
  input logic                   clk,
  input logic                   rst,
  input logic [DATA_W-OP_W-1:0] mem_addr,
  input logic                   mem_we,
  input logic [DATA_W-1:0]      acc_out,
  input logic [DATA_W-OP_W-1:0] pc_out,
  input logic                   halted
);

  localparam int ADDR_W = DATA_W - OP_W;

  logic armed;
  always_ff @(posedge clk) begin
    if (rst) armed <= 1'b0;
    else     armed <= 1'b1;
  end

  // R7
  halt_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    halted |=> halted);

  // R7
  halt_no_write_chk: assert property (@(posedge clk) disable iff (rst)
    halted |-> !mem_we);

  // R7
  halt_frozen_chk: assert property (@(posedge clk) disable iff (rst)
    halted |=> ($stable(pc_out) && $stable(mem_addr)));

  // R5
  we_single_chk: assert property (@(posedge clk) disable iff (rst)
    mem_we |=> !mem_we);

  // R5
  store_keeps_acc_chk: assert property (@(posedge clk) disable iff (rst)
    mem_we |=> $stable(acc_out));

  // R3
  pc_step_chk: assert property (@(posedge clk) disable iff (rst)
    (armed && (pc_out != $past(pc_out))) |-> (pc_out == ADDR_W'($past(pc_out) + 1'b1)));

endmodule

bind acc_core acc_core_chk #(.DATA_W(DATA_W), .OP_W(OP_W)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .mem_addr (mem_addr),
  .mem_we   (mem_we),
  .acc_out  (acc_out),
  .pc_out   (pc_out),
  .halted   (halted)
);

// File: tb/sim_acc_core.sv
`timescale 1ns/1ps
module sim_acc_core;
  localparam int DW = 16;
  localparam int OW = 4;
  localparam int AW = DW - OW;
  localparam int MW = 1 << AW;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [AW-1:0] start_addr = '0;
  logic [AW-1:0] mem_addr;
  logic          mem_we;
  logic [DW-1:0] mem_wdata;
  logic [DW-1:0] mem_rdata = '0;
  logic [DW-1:0] acc_out;
  logic [AW-1:0] pc_out;
  logic          halted;

  always #2.5 clk = ~clk;

  acc_core #(.DATA_W(DW), .OP_W(OW)) u0 (
    .clk(clk), .rst(rst), .start_addr(start_addr),
    .mem_addr(mem_addr), .mem_we(mem_we), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata), .acc_out(acc_out), .pc_out(pc_out), .halted(halted)
  );

  // Memory with one-cycle read latency
  logic [DW-1:0] mem [MW];
  always @(posedge clk) begin
    mem_rdata <= mem[mem_addr];
    if (mem_we) mem[mem_addr] = mem_wdata;
  end

  int checks = 0;
  int fails  = 0;
  bit ran    = 0;

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // Behavioural reference: step counter within an instruction, own memory copy
  logic [DW-1:0] ref_mem [MW];
  int            m_step;
  int            m_pc;
  int            m_acc;
  bit            m_halt;
  int            m_ir;

  function automatic int opc(input int w); return (w >> 12) & 15; endfunction

  always @(posedge clk) begin
    if (rst) begin
      ran = 1; m_pc = int'(start_addr); m_acc = 0; m_halt = 0; m_step = 0; m_ir = 0;
    end else if (!m_halt) begin
      case (m_step)
        3: begin m_ir = int'(ref_mem[m_pc]); m_pc = (m_pc + 1) % MW; m_step = 4; end
        4: begin
          if (opc(m_ir) == 1 || opc(m_ir) == 2 || opc(m_ir) == 5) m_step = 5;
          else m_halt = 1;
        end
        5: begin
          if (opc(m_ir) == 2) begin ref_mem[m_ir & 'hFFF] = m_acc[15:0]; m_step = 0; end
          else m_step = 6;
        end
        7: begin
          if (opc(m_ir) == 1) m_acc = int'(ref_mem[m_ir & 'hFFF]);
          else m_acc = (m_acc + int'(ref_mem[m_ir & 'hFFF])) % 65536;
          m_step = 0;
        end
        default: m_step = m_step + 1;
      endcase
    end
  end

  always @(negedge clk) begin
    if (ran && !rst) begin
      check(acc_out == m_acc[15:0], "R4 R6 acc", acc_out, m_acc);
      check(pc_out == m_pc[AW-1:0], "R3 pc", pc_out, m_pc);
      check(halted == m_halt, "R7 halted", halted, m_halt);
      check(mem_we == (!m_halt && m_step == 5 && opc(m_ir) == 2), "R5 mem_we", mem_we, 0);
      if (!m_halt && m_step == 1)
        check(mem_addr == m_pc[AW-1:0], "R3 R9 fetch addr", mem_addr, m_pc);
      if (!m_halt && m_step == 5) begin
        check(mem_addr == m_ir[AW-1:0], "R2 R9 operand addr", mem_addr, m_ir & 'hFFF);
        if (opc(m_ir) == 2) check(mem_wdata == m_acc[15:0], "R5 R9 wdata", mem_wdata, m_acc);
      end
    end
  end

  task automatic put(input int a, input logic [DW-1:0] v);
    mem[a] = v; ref_mem[a] = v;
  endtask

  task automatic clear_mem();
    for (int i = 0; i < MW; i++) begin mem[i] = '0; ref_mem[i] = '0; end
  endtask

  task automatic start_run(input logic [AW-1:0] sa);
    @(negedge clk); rst = 1'b1; start_addr = sa;
    @(negedge clk); @(negedge clk);
    check(pc_out == sa && acc_out == 0 && !halted && !mem_we, "R1 reset state", {pc_out, acc_out}, {sa, 16'h0});
    rst = 1'b0;
    @(negedge clk);
    check(pc_out == sa && acc_out == 0 && !halted, "R1 after release", pc_out, sa);
  endtask

  task automatic run_to_halt();
    for (int n = 0; n < 400 && !halted; n++) @(negedge clk);
    check(halted, "R7 halt reached", halted, 1);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++; checks++;
    $display("FAIL watchdog R7 actual=running expected=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    // Program 1: load 0x940, add 0x941, store 0x941, then undefined opcode 0
    clear_mem();
    put('h300, 16'h1940); put('h301, 16'h5941); put('h302, 16'h2941); put('h303, 16'h0000);
    put('h940, 16'h0003); put('h941, 16'h0002);
    start_run(12'h300);
    run_to_halt();
    check(mem['h941] == 16'h0005, "R8 sum stored", mem['h941], 16'h0005);
    check(acc_out == 16'h0005, "R6 acc sum", acc_out, 16'h0005);
    check(pc_out == 12'h304, "R7 pc past bad word", pc_out, 12'h304);
    repeat (30) @(negedge clk);
    check(pc_out == 12'h304 && halted, "R7 frozen while halted", pc_out, 12'h304);
    check(mem['h941] == 16'h0005, "R7 no write while halted", mem['h941], 16'h0005);

    // Program 2: wrapping add, halt on opcode 0xF
    @(negedge clk); rst = 1'b1; clear_mem();
    put('h010, 16'h1020); put('h011, 16'h5021); put('h012, 16'h2022); put('h013, 16'hF000);
    put('h020, 16'hFFFF); put('h021, 16'h0003);
    start_run(12'h010);
    run_to_halt();
    check(mem['h022] == 16'h0002, "R6 add wraps", mem['h022], 16'h0002);
    check(pc_out == 12'h014, "R7 pc after 0xF", pc_out, 12'h014);

    // Program 3: counter wraps from 0xFFF, load then store, opcode 3 halts
    @(negedge clk); rst = 1'b1; clear_mem();
    put('hFFE, 16'h1005); put('hFFF, 16'h2006); put('h000, 16'h3000);
    put('h005, 16'h1234);
    start_run(12'hFFE);
    run_to_halt();
    check(mem['h006] == 16'h1234, "R4 R5 load then store", mem['h006], 16'h1234);
    check(acc_out == 16'h1234, "R4 acc loaded", acc_out, 16'h1234);
    check(pc_out == 12'h001, "R3 pc wrap", pc_out, 12'h001);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule